// File: doc/BRIEF.md
# Rotating Three-Character Segment Selector

This block drives three seven-segment positions from three 2-bit character codes. A 2-bit rotate select chooses which code each position shows. Every position holds its own 3-to-1 selector. Each selector sees the same three codes, but its inputs are wired one step further round the ring than the last position's. Moving the select therefore shifts the whole string cyclically across the positions.

The code chosen for each position passes through a small glyph decoder. The decoder gives the letter d, the letter E, the digit 1, or a dark position. Its output is an 8-bit pattern in which a lit segment is a 0. Logic that wants a rotating marquee, for example, can load the three codes once and step only the select. The block is purely combinational and has no clock or reset.

Top module: `rot_char_disp`

## Requirements
- R1: With rot_sel_i = 00, position p (0..2) shows character code p. seg0_o shows char0_i, seg1_o shows char1_i and seg2_o shows char2_i.
- R2: With rot_sel_i = 01, position p shows character code (p+1) mod 3. seg0_o shows char1_i, seg1_o shows char2_i and seg2_o shows char0_i.
- R3: With rot_sel_i = 10, position p shows character code (p+2) mod 3. seg0_o shows char2_i, seg1_o shows char0_i and seg2_o shows char1_i.
- R4: With rot_sel_i = 11, every position shows the same character it shows for rot_sel_i = 10.
- R5: Character code 00 decodes to the letter d, pattern 8'b1010_0001. Segment a is bit 0 and segment g is bit 6, and a 0 lights the segment.
- R6: Character code 01 decodes to the letter E, pattern 8'b1000_0110.
- R7: Character code 10 decodes to the digit 1, pattern 8'b1111_1001.
- R8: Character code 11 decodes to a dark position, pattern 8'hFF.
- R9: Bit 7 of every segment output, the decimal point, is 1 (off) for every input.
- R10: The outputs depend only on the present inputs and follow any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| char0_i | input | 2 | Character code 0 |
| char1_i | input | 2 | Character code 1 |
| char2_i | input | 2 | Character code 2 |
| rot_sel_i | input | 2 | Rotate select, 00 to 11 |
| seg0_o | output | 8 | Active-low segment pattern for position 0 |
| seg1_o | output | 8 | Active-low segment pattern for position 1 |
| seg2_o | output | 8 | Active-low segment pattern for position 2 |

## Verification
The hardest case to reach is select 11. Its output must match select 10, yet no port reveals which mux input was taken. A fault there shows only when the three codes differ. The sweep therefore drives all 64 code combinations under each of the four select values. Many of those combinations have three distinct codes, so a wrong alias or a mis-rotated wire changes at least one visible glyph. The same sweep also places the blank code at every position under every rotation.

// File: rtl/rot_char_disp.sv
module rot_char_disp (
  input  logic [1:0] char0_i,
  input  logic [1:0] char1_i,
  input  logic [1:0] char2_i,
  input  logic [1:0] rot_sel_i,
  output logic [7:0] seg0_o,
  output logic [7:0] seg1_o,
  output logic [7:0] seg2_o
);

  localparam int NPOS   = 3;
  localparam int CODE_W = 2;
  localparam int SEG_W  = 8;

  logic [CODE_W-1:0] chars [NPOS];
  logic [SEG_W-1:0]  segs  [NPOS];

  assign chars[0] = char0_i;
  assign chars[1] = char1_i;
  assign chars[2] = char2_i;

  wire s1 = rot_sel_i[1];
  wire s0 = rot_sel_i[0];

  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    logic [CODE_W-1:0] u, v, w, pick;
    assign u = chars[p];
    assign v = chars[(p + 1) % NPOS];
    assign w = chars[(p + 2) % NPOS];

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
      assign pick[b] = (s1 & w[b]) | (~s1 & ~s0 & u[b]) | (~s1 & s0 & v[b]);
    end

    always_comb begin
      unique case (pick)
        2'b00:   segs[p] = 8'b1010_0001;
        2'b01:   segs[p] = 8'b1000_0110;
        2'b10:   segs[p] = 8'b1111_1001;
        default: segs[p] = 8'b1111_1111;
      endcase
    end
  end

  assign seg0_o = segs[0];
  assign seg1_o = segs[1];
  assign seg2_o = segs[2];

endmodule

// File: rtl/rot_char_disp_chk.sv
module rot_char_disp_chk (
  input logic [1:0] char0_i,
  input logic [1:0] char1_i,
  input logic [1:0] char2_i,
  input logic [1:0] rot_sel_i,
  input logic [7:0] seg0_o,
  input logic [7:0] seg1_o,
  input logic [7:0] seg2_o
);

  always_comb begin
    AST_DP_OFF: assert (seg0_o[7] && seg1_o[7] && seg2_o[7]) else $error("dp lit"); // R9
    AST_HOME_BLANK: assert (!(rot_sel_i == 2'b00 && char0_i == 2'b11) || seg0_o == 8'hFF) else $error("home blank"); // R8
    AST_STEP1_D: assert (!(rot_sel_i == 2'b01 && char1_i == 2'b00) || seg0_o == 8'hA1) else $error("step1 d"); // R2
    AST_STEP2_E: assert (!(rot_sel_i[1] && char2_i == 2'b01) || seg0_o == 8'h86) else $error("step2 E"); // R4
    AST_HOME_ONE: assert (!(rot_sel_i == 2'b00 && char2_i == 2'b10) || seg2_o == 8'hF9) else $error("home one"); // R7
    AST_SAME_CHARS: assert (!(char0_i == char1_i && char1_i == char2_i) || (seg0_o == seg1_o && seg1_o == seg2_o)) else $error("uniform"); // R1
  end

endmodule

bind rot_char_disp rot_char_disp_chk chk_i (.*);

// File: tb/rot_char_disp_tb_top.sv
`timescale 1ns/1ps
module rot_char_disp_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] c0, c1, c2, sel;
  logic [7:0] s0, s1, s2;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  rot_char_disp dut_i (
    .char0_i(c0), .char1_i(c1), .char2_i(c2), .rot_sel_i(sel),
    .seg0_o(s0), .seg1_o(s1), .seg2_o(s2)
  );

  function automatic logic [7:0] glyph(input logic [1:0] code);
    case (code)
      2'd0:    return 8'hA1;
      2'd1:    return 8'h86;
      2'd2:    return 8'hF9;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string code_req(input logic [1:0] code);
    case (code)
      2'd0:    return "R5";
      2'd1:    return "R6";
      2'd2:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (sel=%b c=%b %b %b)", req, act, exp, sel, c0, c1, c2);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] codes [3];
    logic [7:0] outs [3];
    string sreq;
    int offs;

    c0 = 2'd0; c1 = 2'd0; c2 = 2'd0; sel = 2'd0;
    @(posedge clk); #1;
    chk("R5 initial seg0", s0, 8'hA1);
    chk("R5 initial seg1", s1, 8'hA1);
    chk("R5 initial seg2", s2, 8'hA1);

    // R10: change inputs between edges and sample without waiting for a clock edge
    @(negedge clk);
    c0 = 2'd1; c1 = 2'd2; c2 = 2'd3; sel = 2'd0;
    #1;
    chk("R10 seg0", s0, 8'h86);
    sel = 2'd1;
    #1;
    chk("R10 seg0 after sel", s0, 8'hF9);

    for (int sv = 0; sv < 4; sv++) begin
      for (int cv = 0; cv < 64; cv++) begin
        @(negedge clk);
        sel = 2'(sv);
        c0 = 2'(cv);
        c1 = 2'(cv >> 2);
        c2 = 2'(cv >> 4);
        @(posedge clk); #2;
        codes[0] = c0; codes[1] = c1; codes[2] = c2;
        outs[0] = s0; outs[1] = s1; outs[2] = s2;
        offs = (sv == 0) ? 0 : (sv == 1) ? 1 : 2;
        sreq = (sv == 0) ? "R1" : (sv == 1) ? "R2" : (sv == 2) ? "R3" : "R4";
        for (int p = 0; p < 3; p++) begin
          logic [1:0] code;
          code = codes[(p + offs) % 3];
          chk({sreq, "/", code_req(code)}, outs[p], glyph(code));
          checks++;
          if (outs[p][7] !== 1'b1) begin
            errors++;
            $display("FAIL R9: actual=%b expected=1 pos=%0d", outs[p][7], p);
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule